// File: doc/BRIEF.md
# Float/Integer Conversion Unit

The unit converts single-precision floating-point values to and from integers, one operation at a time. Going to float, a 32-bit two's-complement integer becomes a normalised single-precision value rounded to nearest-even. Going to integer, a single-precision value becomes a 32-bit signed, 16-bit signed or 16-bit unsigned integer. The fraction is either cut toward zero or rounded to nearest-even. A result that does not fit the chosen type raises a range trap, and so do the float encodings the unit does not handle: denormals, infinities and NaNs.

An operation enters on a valid/ready input handshake. The input is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the unit is idle, so the operand, direction, kind and mode need to be held only until that edge. The outcome is presented on a valid/ready output handshake. While `out_valid` is high and `out_ready` is low, the outputs stay frozen. The unit becomes idle on the edge where both are high, and it takes no new input before then. On a trap, `out_result` keeps the last successful result, and only `out_trap` reports the failure.

Top module: `numconv_unit`

## Requirements
- R1: `in_ready` is high only while idle. After the edge that accepts an input, `out_valid` is low after one more edge and high after two.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result`, `out_trap` and `out_inexact` hold. After an edge with both high, `out_valid` is low and `in_ready` is high.
- R3: Integer to float (`in_to_float`=1) with operand 0 gives 0x00000000, with no inexact flag.
- R4: Integer to float takes the sign from bit 31 and converts the magnitude. It uses exponent field 158 minus the number of leading zeros, keeps 24 significant bits, and rounds the 8 bits below them to nearest-even. A carry out of rounding raises the exponent by one. `out_inexact` is set when the dropped bits are non-zero. This direction never traps and ignores `in_kind` and `in_round`.
- R5: Float to integer with exponent field 0 and fraction 0, of either sign, gives 0 with no trap for kinds 0 to 2.
- R6: Float to integer traps on exponent field 255, or on exponent field 0 with a non-zero fraction.
- R7: With `in_round`=0 the magnitude is cut toward zero and `out_inexact` stays 0.
- R8: With `in_round`=1 the magnitude is rounded to nearest, ties to even. `out_inexact` is set when any dropped bit is non-zero.
- R9: A negative float gives the two's-complement negation of its magnitude. A kind-1 result is sign-extended to 32 bits.
- R10: Kind 0 (32-bit signed) traps when the magnitude exceeds 2^31, or equals 2^31 with a positive sign. -2^31 gives 0x80000000.
- R11: Kind 1 (16-bit signed) traps when the magnitude is 32768 or more, for either sign.
- R12: Kind 2 (16-bit unsigned) traps when the magnitude is 65536 or more, or when the sign is negative and the magnitude is non-zero. Its result is zero-extended.
- R13: Kind 3 is reserved and traps every float-to-integer request.
- R14: On a trap, `out_result` keeps the value of the last non-trapping operation (0 after reset) and `out_inexact` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Unit idle, request accepted on this edge |
| in_operand | input | 32 | Integer or float bit pattern |
| in_to_float | input | 1 | 1: integer to float, 0: float to integer |
| in_kind | input | 2 | Integer type: 0 s32, 1 s16, 2 u16, 3 reserved |
| in_round | input | 1 | 1: round to nearest-even, 0: truncate |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Converted value |
| out_trap | output | 1 | Range or encoding trap |
| out_inexact | output | 1 | Non-zero bits were dropped while rounding |

## Verification
Every result is due exactly two rising edges after the edge that accepts its input. The bench drives and samples only on falling edges. It checks that `out_valid` is still low one edge after acceptance and high one edge later, and it compares the result at that point against its own reference functions. It then holds `out_ready` low for zero to two more cycles and checks that nothing moves. One edge after releasing the output, it checks that the unit is idle again.

// File: rtl/numconv_pkg.sv
package numconv_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 32;
  localparam int HALF_W  = WORD_W / 2;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_TOP = (1 << EXP_W) - 1;

  typedef enum logic [1:0] {
    KIND_S32 = 2'd0,
    KIND_S16 = 2'd1,
    KIND_U16 = 2'd2,
    KIND_RSV = 2'd3
  } int_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_HOLD = 2'd2
  } conv_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] value;
    logic              trap;
    logic              inexact;
  } conv_res_t;
endpackage

// File: rtl/numconv_to_float.sv
module numconv_to_float
  import numconv_pkg::*;
(
  input  logic [WORD_W-1:0] op,
  output conv_res_t         res
);
  localparam int START  = BIAS + WORD_W - 1;
  localparam int DROP_W = WORD_W - SIG_W;
  localparam int LZ_W   = $clog2(WORD_W);

  logic              sgn;
  logic [WORD_W-1:0] mag;
  logic [WORD_W-1:0] norm;
  logic [LZ_W-1:0]   lz;
  logic              found;
  logic              lbit, rbit, sticky, inc;
  logic [SIG_W:0]    sum;
  logic [EXP_W-1:0]  expo;

  always_comb begin
    sgn   = op[WORD_W-1];
    mag   = sgn ? (WORD_W'(0) - op) : op;
    lz    = '0;
    found = 1'b0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (!found && mag[i]) begin
        lz    = LZ_W'(WORD_W - 1 - i);
        found = 1'b1;
      end
    end
    norm   = mag << lz;
    lbit   = norm[DROP_W];
    rbit   = norm[DROP_W-1];
    sticky = |norm[DROP_W-2:0];
    inc    = rbit & (sticky | lbit);
    sum    = {1'b0, norm[WORD_W-1 -: SIG_W]} + (SIG_W+1)'(inc);
    expo   = EXP_W'(START) - EXP_W'(lz) + EXP_W'(sum[SIG_W]);
    res.trap = 1'b0;
    if (op == '0) begin
      res.value   = '0;
      res.inexact = 1'b0;
    end else begin
      res.value   = {sgn, expo, sum[FRAC_W-1:0]};
      res.inexact = rbit | sticky;
    end
  end
endmodule

// File: rtl/numconv_to_int.sv
module numconv_to_int
  import numconv_pkg::*;
(
  input  logic [WORD_W-1:0] op,
  input  int_kind_e         kind,
  input  logic              rnd,
  output conv_res_t         res
);
  localparam int SHIFT_BASE = BIAS + WORD_W - 2;
  localparam int PAD        = WORD_W - 2 - FRAC_W;
  localparam int SH_W       = EXP_W + 2;
  localparam int SC_W       = $clog2(WORD_W) + 1;
  localparam logic [WORD_W:0] TOP_MAG = {2'b01, {(WORD_W-1){1'b0}}};

  logic                     sgn;
  logic [EXP_W-1:0]         ex;
  logic [FRAC_W-1:0]        fr;
  logic [WORD_W-1:0]        x;
  logic signed [SH_W-1:0]   sh;
  logic [SC_W-1:0]          sc;
  logic [2*WORD_W-1:0]      wide;
  logic [WORD_W:0]          mag;
  logic                     rbit, sticky, inc, over;

  always_comb begin
    sgn    = op[WORD_W-1];
    ex     = op[WORD_W-2 -: EXP_W];
    fr     = op[FRAC_W-1:0];
    x      = {1'b0, 1'b1, fr, {PAD{1'b0}}};
    sh     = SH_W'(SHIFT_BASE) - SH_W'(ex);
    sc     = '0;
    wide   = '0;
    rbit   = 1'b0;
    sticky = 1'b0;
    over   = 1'b0;
    if (sh[SH_W-1]) begin
      mag  = {x, 1'b0};
      over = (sh != '1);
    end else begin
      if (sh[SH_W-2:0] >= (SH_W-1)'(WORD_W)) sc = SC_W'(WORD_W);
      else                                   sc = sh[SC_W-1:0];
      wide   = {x, {WORD_W{1'b0}}} >> sc;
      rbit   = wide[WORD_W-1];
      sticky = |wide[WORD_W-2:0];
      mag    = {1'b0, wide[2*WORD_W-1:WORD_W]};
    end
    inc = rnd & rbit & (sticky | mag[0]);
    mag = mag + (WORD_W+1)'(inc);

    res.value   = sgn ? (WORD_W'(0) - mag[WORD_W-1:0]) : mag[WORD_W-1:0];
    res.inexact = rnd & (rbit | sticky);
    unique case (kind)
      KIND_S32: res.trap = over || (mag > TOP_MAG) || (mag == TOP_MAG && !sgn);
      KIND_S16: res.trap = over || (|mag[WORD_W:HALF_W-1]);
      KIND_U16: res.trap = over || (|mag[WORD_W:HALF_W]) || (sgn && |mag);
      default:  res.trap = 1'b1;
    endcase

    if (kind == KIND_RSV) begin
      res.trap = 1'b1;
    end else if (ex == '0 && fr == '0) begin
      res.value = '0;
      res.trap  = 1'b0;
      res.inexact = 1'b0;
    end else if (ex == '0 || ex == EXP_W'(EXP_TOP)) begin
      res.trap = 1'b1;
    end
    if (res.trap) res.inexact = 1'b0;
  end
endmodule

// File: rtl/numconv_unit.sv
module numconv_unit
  import numconv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_operand,
  input  logic              in_to_float,
  input  logic [1:0]        in_kind,
  input  logic              in_round,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result,
  output logic              out_trap,
  output logic              out_inexact
);
  conv_state_e       state;
  logic [WORD_W-1:0] op_q;
  logic              dir_q;
  int_kind_e         kind_q;
  logic              rnd_q;
  logic [WORD_W-1:0] res_q;
  logic              trap_q, inx_q;
  conv_res_t         f_res, i_res, sel;

  numconv_to_float u_to_float (.op(op_q), .res(f_res));
  numconv_to_int   u_to_int   (.op(op_q), .kind(kind_q), .rnd(rnd_q), .res(i_res));

  assign sel = dir_q ? f_res : i_res;

  assign in_ready    = (state == ST_IDLE);
  assign out_valid   = (state == ST_HOLD);
  assign out_result  = res_q;
  assign out_trap    = trap_q;
  assign out_inexact = inx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      op_q   <= '0;
      dir_q  <= 1'b0;
      kind_q <= KIND_S32;
      rnd_q  <= 1'b0;
      res_q  <= '0;
      trap_q <= 1'b0;
      inx_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          op_q   <= in_operand;
          dir_q  <= in_to_float;
          kind_q <= int_kind_e'(in_kind);
          rnd_q  <= in_round;
          state  <= ST_CALC;
        end
        ST_CALC: begin
          trap_q <= sel.trap;
          inx_q  <= sel.inexact;
          if (!sel.trap) res_q <= sel.value;
          state  <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_GAP: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |=> !out_valid); // R1
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_ready) |-> ##2 out_valid); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_trap) && $stable(out_inexact))); // R2
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_ready) |=> (!out_valid && in_ready)); // R2
  AST_FLOAT_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && dir_q) |-> !out_trap); // R4
  AST_S16_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !dir_q && !out_trap && kind_q == KIND_S16) |-> (out_result[WORD_W-1:HALF_W-1] == '0 || out_result[WORD_W-1:HALF_W-1] == '1)); // R11
  AST_U16_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !dir_q && !out_trap && kind_q == KIND_U16) |-> (out_result[WORD_W-1:HALF_W] == '0)); // R12
  AST_TRAP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n) ($rose(out_valid) && out_trap) |-> $stable(out_result)); // R14
  AST_TRAP_NO_INEXACT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_trap) |-> !out_inexact); // R14
endmodule

// File: tb/numconv_unit_bench.sv
module numconv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_operand = '0;
  logic        in_to_float = 1'b0;
  logic [1:0]  in_kind = 2'd0;
  logic        in_round = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_trap;
  logic        out_inexact;

  int total = 0;
  int bad = 0;
  logic [31:0] last_res = '0;

  always #4 clk = ~clk;

  numconv_unit u_numconv_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_to_float(in_to_float), .in_kind(in_kind),
    .in_round(in_round), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_trap(out_trap), .out_inexact(out_inexact)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void ref_i2f(input logic [31:0] v, output logic [31:0] r, output bit inx);
    logic [63:0] m, q, rem, half;
    int p, e, d;
    bit s;
    r = '0; inx = 0;
    if (v == 32'd0) return;
    s = v[31];
    m = s ? (64'h1_0000_0000 - {32'd0, v}) : {32'd0, v};
    p = -1;
    for (int i = 31; i >= 0; i--) if (p < 0 && m[i]) p = i;
    e = 127 + p;
    if (p <= 23) begin
      q = m << (23 - p);
    end else begin
      d = p - 23;
      q = m >> d;
      rem = m - (q << d);
      half = 64'd1 << (d - 1);
      if (rem > half || (rem == half && q[0])) q = q + 64'd1;
      inx = (rem != 64'd0);
      if (q == (64'd1 << 24)) begin
        q = q >> 1;
        e = e + 1;
      end
    end
    r = {s, 8'(e), q[22:0]};
  endfunction

  function automatic void ref_f2i(input logic [31:0] f, input logic [1:0] kind, input bit rnd,
                                  output logic [31:0] r, output bit trap, output bit inx);
    logic [63:0] m, q, rem, half, mag;
    int e, d;
    bit s;
    r = '0; trap = 0; inx = 0;
    if (kind == 2'd3) begin trap = 1; return; end
    s = f[31];
    e = int'(f[30:23]);
    if (e == 0 && f[22:0] == 23'd0) return;
    if (e == 0 || e == 255 || e >= 182) begin trap = 1; return; end
    m = {40'd1, f[22:0]};
    if (e >= 150) begin
      mag = m << (e - 150);
    end else begin
      d = 150 - e;
      if (d > 40) begin
        mag = 64'd0;
        inx = rnd;
      end else begin
        q = m >> d;
        rem = m - (q << d);
        half = 64'd1 << (d - 1);
        if (rnd && (rem > half || (rem == half && q[0]))) q = q + 64'd1;
        inx = rnd && (rem != 64'd0);
        mag = q;
      end
    end
    case (kind)
      2'd0: trap = (mag > 64'h8000_0000) || (mag == 64'h8000_0000 && !s);
      2'd1: trap = (mag > 64'd32767);
      default: trap = (mag > 64'd65535) || (s && mag != 64'd0);
    endcase
    if (trap) begin inx = 0; return; end
    r = s ? (32'd0 - mag[31:0]) : mag[31:0];
  endfunction

  task automatic run_op(input bit tf, input logic [1:0] kd, input bit rd, input logic [31:0] opnd,
                        input int hold, input string tag);
    logic [31:0] er, snap;
    bit et, ei;
    et = 0;
    if (tf) ref_i2f(opnd, er, ei);
    else    ref_f2i(opnd, kd, rd, er, et, ei);
    if (et) er = last_res;
    @(negedge clk);
    in_valid = 1'b1; in_to_float = tf; in_kind = kd; in_round = rd; in_operand = opnd;
    chk(in_ready == 1'b1, "R1 ready", {31'd0, in_ready}, 32'd1);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R1 gap", {31'd0, out_valid}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk(out_valid == 1'b1, "R1 due", {31'd0, out_valid}, 32'd1);
    snap = out_result;
    for (int k = 0; k < hold; k++) begin
      @(posedge clk); @(negedge clk);
      chk(out_valid && out_result == snap, "R2 hold", out_result, snap);
    end
    chk(out_result == er, tag, out_result, er);
    chk(out_trap == et, tag, {31'd0, out_trap}, {31'd0, et});
    chk(out_inexact == ei, tag, {31'd0, out_inexact}, {31'd0, ei});
    if (et) chk(out_result == last_res && !out_inexact, "R14 trap keeps result", out_result, last_res);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
    chk(!out_valid && in_ready, "R2 release", {30'd0, out_valid, in_ready}, 32'd1);
    if (!et) last_res = er;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0 && out_result == 32'd0 && !out_trap && !out_inexact,
        "R1 reset", {27'd0, in_ready, out_valid, out_trap, out_inexact, 1'b0}, 32'h10);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(1, 2'd0, 0, 32'd0, 0, "R3 zero int");
    run_op(1, 2'd3, 1, 32'd1, 1, "R4 one");
    run_op(1, 2'd1, 0, 32'hFFFF_FFFF, 2, "R4 minus one");
    run_op(1, 2'd0, 0, 32'h8000_0000, 0, "R4 most negative");
    run_op(1, 2'd0, 0, 32'h7FFF_FFFF, 0, "R4 round carry");
    run_op(1, 2'd0, 0, 32'h0100_0001, 0, "R4 tie even");
    run_op(1, 2'd0, 0, 32'h0100_0003, 0, "R4 tie up");

    run_op(0, 2'd2, 1, 32'h0000_0000, 0, "R5 plus zero");
    run_op(0, 2'd1, 0, 32'h8000_0000, 0, "R5 minus zero");
    run_op(0, 2'd0, 0, 32'h7F80_0000, 1, "R6 infinity");
    run_op(0, 2'd0, 1, 32'h0000_0001, 0, "R6 denormal");
    run_op(0, 2'd2, 0, 32'h7FC0_0000, 0, "R6 nan");
    run_op(0, 2'd0, 0, 32'h4020_0000, 0, "R7 trunc 2.5");
    run_op(0, 2'd0, 0, 32'hC060_0000, 0, "R7 trunc -3.5");
    run_op(0, 2'd0, 1, 32'h4020_0000, 0, "R8 round 2.5");
    run_op(0, 2'd0, 1, 32'h4060_0000, 0, "R8 round 3.5");
    run_op(0, 2'd0, 1, 32'h3F40_0000, 0, "R8 round 0.75");
    run_op(0, 2'd0, 1, 32'hC020_0000, 0, "R9 round -2.5");
    run_op(0, 2'd1, 0, 32'hBF80_0000, 0, "R9 s16 minus one");
    run_op(0, 2'd0, 0, 32'hCF00_0000, 0, "R10 minus 2^31");
    run_op(0, 2'd0, 0, 32'h4F00_0000, 0, "R10 plus 2^31");
    run_op(0, 2'd0, 0, 32'hCF00_0001, 0, "R10 beyond");
    run_op(0, 2'd0, 1, 32'h4EFF_FFFF, 0, "R10 top in range");
    run_op(0, 2'd1, 0, 32'h46FF_FE00, 0, "R11 32767");
    run_op(0, 2'd1, 0, 32'h4700_0000, 0, "R11 32768");
    run_op(0, 2'd1, 0, 32'hC700_0000, 0, "R11 -32768");
    run_op(0, 2'd1, 1, 32'h46FF_FF00, 0, "R11 rounds over");
    run_op(0, 2'd2, 0, 32'h477F_FF00, 0, "R12 65535");
    run_op(0, 2'd2, 0, 32'h4780_0000, 0, "R12 65536");
    run_op(0, 2'd2, 0, 32'hBF80_0000, 0, "R12 minus one");
    run_op(0, 2'd2, 1, 32'hBE80_0000, 0, "R12 minus quarter");
    run_op(0, 2'd3, 0, 32'h3F80_0000, 0, "R13 reserved kind");
    run_op(0, 2'd3, 1, 32'h0000_0000, 0, "R13 reserved zero");

    for (int n = 0; n < 300; n++) begin
      logic [31:0] v;
      v = $urandom;
      if (n % 3 == 0) v = v >> ($urandom % 32);
      run_op(1, 2'($urandom), 1'($urandom), v, int'($urandom % 3), "R4 random");
    end
    for (int n = 0; n < 400; n++) begin
      logic [31:0] f;
      logic [7:0]  e;
      bit rd;
      e = 8'(110 + ($urandom % 52));
      rd = 1'($urandom);
      f = {1'($urandom), e, 23'($urandom)};
      if (rd) run_op(0, 2'($urandom % 3), 1, f, int'($urandom % 3), "R8 random");
      else    run_op(0, 2'($urandom % 3), 0, f, int'($urandom % 3), "R7 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule